// File: doc/BRIEF.md
# Store Queue with Read-After-Write Guard

This block sits between a write-through cache and a slower lower-level memory. The cache hands it store address/data pairs. It keeps them in a small circular queue, so the processor keeps running while the stores wait. Stored entries leave toward memory oldest first, one per cycle in which the memory accepts a transfer. The queue shares a single request port toward memory with the reads that the cache sends down on a miss.

A read that goes to memory while an older store to the same address still waits in the queue would return stale data. A build-time parameter picks one of two ways to avoid this:

- **Flush mode** empties the whole queue before the read may go out.
- **Check mode** compares the read address with every waiting entry. A read with no match goes to memory at once, ahead of the waiting stores. A matching read is either answered on the spot from the youngest matching entry, or held until that entry has drained, as a second parameter selects.

Top module: `wbq_top`

## Requirements
- R1: After reset the queue is empty: `empty` is 1, `full` is 0, `memValid` is 0 and `stReady` is 1.
- R2: A store is taken on a clock edge where `stValid` and `stReady` are both 1. In check mode, `stReady` is 0 only while all DEPTH entries are occupied. A store offered while the queue is full is not taken.
- R3: Stores are written to memory (`memValid`=1, `memWrite`=1) in the order they were taken. Each edge with `memReady`=1 completes exactly one such write, carrying that entry's address and data.
- R4: `full` is 1 exactly when DEPTH entries are held, and `empty` is 1 exactly when none are held.
- R5: In check mode, a read whose address matches no waiting entry takes the memory port ahead of draining (`memValid`=1, `memWrite`=0, `memAddr` = read address). `rdReqReady` then equals `memReady`.
- R6: In check mode with forwarding, a matching read completes in the same cycle: `rdReqReady`=1 and `fwdValid`=1, and `fwdData` is the data of the youngest matching entry. The read is not sent to memory, and the memory port keeps draining the oldest entry.
- R7: In check mode without forwarding, a matching read is held (`rdReqReady`=0) while the queue drains. It is issued to memory in the first cycle in which no waiting entry matches its address.
- R8: In flush mode, a pending read is not issued until the queue is empty, and `stReady` is 0 while the read waits.
- R9: A store taken in the same cycle as a read is ordered after that read. It is not compared against the read's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stValid | input | 1 | Store offered |
| stReady | output | 1 | Store can be taken |
| stAddr | input | ADDR_W | Store address |
| stData | input | DATA_W | Store data |
| rdReqValid | input | 1 | Read miss wants to go to memory |
| rdReqAddr | input | ADDR_W | Read address |
| rdReqReady | output | 1 | Read accepted (issued to memory or forwarded) |
| fwdValid | output | 1 | Read answered from the queue this cycle |
| fwdData | output | DATA_W | Forwarded data |
| memValid | output | 1 | Memory request valid |
| memWrite | output | 1 | 1 = queued write, 0 = read |
| memAddr | output | ADDR_W | Memory request address |
| memWdata | output | DATA_W | Write data |
| memReady | input | 1 | Memory accepts the request |
| empty | output | 1 | No entries held |
| full | output | 1 | All entries held |

## Verification
The bench builds three copies of the block, all with depth 4, an 8-bit address and 16-bit data. The first uses check mode with forwarding. It covers backpressure at full, in-order drain, reads that bypass the queue, youngest-entry forwarding, and the same-cycle store/read ordering. The second uses check mode without forwarding, which brings the cycle-by-cycle hold of a matching read into reach. The third uses flush mode, where a read must wait for an empty queue while stores are refused.

// File: rtl/wbq_pkg.sv
package wbq_pkg;

  typedef enum logic {
    HAZ_FLUSH = 1'b0,
    HAZ_CHECK = 1'b1
  } wbq_haz_e;

  // control -> datapath strobes
  typedef struct packed {
    logic push;
    logic pop;
  } wbq_strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic empty;
    logic full;
    logic match;
  } wbq_status_t;

endpackage

// File: rtl/wbq_datapath.sv
module wbq_datapath #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  wbq_pkg::wbq_strobe_t strobe,
  input  logic [ADDR_W-1:0]    stAddr,
  input  logic [DATA_W-1:0]    stData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output wbq_pkg::wbq_status_t status,
  output logic [ADDR_W-1:0]    headAddr,
  output logic [DATA_W-1:0]    headData,
  output logic [DATA_W-1:0]    fwdData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLCNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [PTR_W-1:0]  headPtr, tailPtr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // storage (no reset needed on payload)
  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrMem[tailPtr] <= stAddr;
      dataMem[tailPtr] <= stData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strobe.push) tailPtr <= ptrInc(tailPtr);
      if (strobe.pop)  headPtr <= ptrInc(headPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // scan oldest to youngest; the last hit wins, giving the youngest match
  logic                hit;
  logic [DATA_W-1:0]   hitData;
  always_comb begin
    hit     = 1'b0;
    hitData = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int s;
      s = int'(headPtr) + i;
      if (s >= DEPTH) s = s - DEPTH;
      if ((CNT_W'(i) < count) && (addrMem[PTR_W'(s)] == rdAddr)) begin
        hit     = 1'b1;
        hitData = dataMem[PTR_W'(s)];
      end
    end
  end

  assign status.empty = (count == '0);
  assign status.full  = (count == FULLCNT);
  assign status.match = hit;
  assign headAddr     = addrMem[headPtr];
  assign headData     = dataMem[headPtr];
  assign fwdData      = hitData;

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.push |-> (count < FULLCNT));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pop |-> (count != '0));
  p_count_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.push && !strobe.pop) |=> (count == $past(count) + 1'b1));
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.pop && !strobe.push) |=> (count == $past(count) - 1'b1));
  p_head_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.pop |=> $stable(headPtr));

endmodule

// File: rtl/wbq_ctrl.sv
module wbq_ctrl #(
  parameter wbq_pkg::wbq_haz_e HAZARD = wbq_pkg::HAZ_CHECK,
  parameter bit                FWD_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  wbq_pkg::wbq_status_t status,
  input  logic                 stValid,
  input  logic                 rdReqValid,
  input  logic                 memReady,
  output wbq_pkg::wbq_strobe_t strobe,
  output logic                 stReady,
  output logic                 rdReqReady,
  output logic                 fwdValid,
  output logic                 memValid,
  output logic                 memWrite
);
  logic readGo, fwdGo, holdStores;

  generate
    if (HAZARD == wbq_pkg::HAZ_CHECK) begin : g_check
      assign readGo     = rdReqValid && !status.match;
      assign fwdGo      = FWD_EN && rdReqValid && status.match;
      assign holdStores = 1'b0;
    end else begin : g_flush
      assign readGo     = rdReqValid && status.empty;
      assign fwdGo      = 1'b0;
      assign holdStores = rdReqValid;

      p_flush_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (memValid && !memWrite) |-> status.empty);
      p_no_store_while_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rdReqValid |-> !strobe.push);
    end
  endgenerate

  assign memValid    = readGo || !status.empty;
  assign memWrite    = !readGo;
  assign rdReqReady  = (readGo && memReady) || fwdGo;
  assign fwdValid    = fwdGo;
  assign stReady     = !status.full && !holdStores;
  assign strobe.push = stValid && stReady;
  assign strobe.pop  = !readGo && !status.empty && memReady;

  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !memWrite) |-> !status.match);
  p_fwd_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fwdValid |-> (status.match && rdReqValid && !(memValid && !memWrite)));
  p_hold_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!FWD_EN && rdReqValid && status.match) |-> !rdReqReady);
  p_one_use_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.pop && readGo));

endmodule

// File: rtl/wbq_top.sv
module wbq_top #(
  parameter int                ADDR_W = 32,
  parameter int                DATA_W = 32,
  parameter int                DEPTH  = 4,
  parameter wbq_pkg::wbq_haz_e HAZARD = wbq_pkg::HAZ_CHECK,
  parameter bit                FWD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stValid,
  output logic              stReady,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic              rdReqValid,
  input  logic [ADDR_W-1:0] rdReqAddr,
  output logic              rdReqReady,
  output logic              fwdValid,
  output logic [DATA_W-1:0] fwdData,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  output logic              empty,
  output logic              full
);
  wbq_pkg::wbq_strobe_t strobe;
  wbq_pkg::wbq_status_t status;
  logic [ADDR_W-1:0]    headAddr;
  logic [DATA_W-1:0]    headData;

  wbq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .stAddr(stAddr), .stData(stData),
    .rdAddr(rdReqAddr), .status(status), .headAddr(headAddr), .headData(headData),
    .fwdData(fwdData)
  );

  wbq_ctrl #(.HAZARD(HAZARD), .FWD_EN(FWD_EN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .status(status), .stValid(stValid),
    .rdReqValid(rdReqValid), .memReady(memReady), .strobe(strobe),
    .stReady(stReady), .rdReqReady(rdReqReady), .fwdValid(fwdValid),
    .memValid(memValid), .memWrite(memWrite)
  );

  assign memAddr  = memWrite ? headAddr : rdReqAddr;
  assign memWdata = headData;
  assign empty    = status.empty;
  assign full     = status.full;

  p_stall_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stReady |-> (full || (HAZARD == wbq_pkg::HAZ_FLUSH && rdReqValid)));
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !rdReqValid) |-> !memValid);

endmodule

// File: tb/wbq_top_tb.sv
module wbq_top_tb;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic          stValid = 0, rdValid = 0, memReady = 0;
  logic [AW-1:0] stAddr = '0, rdAddr = '0;
  logic [DW-1:0] stData = '0;

  // u_dut: check + forward; u_nofwd: check, no forward; u_flush: flush mode
  logic          aStR, aRdR, aFwV, aMV, aMW, aE, aF;
  logic [DW-1:0] aFwD, aWd;
  logic [AW-1:0] aMA;
  logic          bStR, bRdR, bFwV, bMV, bMW, bE, bF;
  logic [DW-1:0] bFwD, bWd;
  logic [AW-1:0] bMA;
  logic          cStR, cRdR, cFwV, cMV, cMW, cE, cF;
  logic [DW-1:0] cFwD, cWd;
  logic [AW-1:0] cMA;

  wbq_top #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4), .HAZARD(wbq_pkg::HAZ_CHECK), .FWD_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .stValid(stValid), .stReady(aStR), .stAddr(stAddr), .stData(stData),
    .rdReqValid(rdValid), .rdReqAddr(rdAddr), .rdReqReady(aRdR), .fwdValid(aFwV), .fwdData(aFwD),
    .memValid(aMV), .memWrite(aMW), .memAddr(aMA), .memWdata(aWd), .memReady(memReady),
    .empty(aE), .full(aF));
  wbq_top #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4), .HAZARD(wbq_pkg::HAZ_CHECK), .FWD_EN(1'b0)) u_nofwd (
    .clk(clk), .rst_n(rst_n), .stValid(stValid), .stReady(bStR), .stAddr(stAddr), .stData(stData),
    .rdReqValid(rdValid), .rdReqAddr(rdAddr), .rdReqReady(bRdR), .fwdValid(bFwV), .fwdData(bFwD),
    .memValid(bMV), .memWrite(bMW), .memAddr(bMA), .memWdata(bWd), .memReady(memReady),
    .empty(bE), .full(bF));
  wbq_top #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4), .HAZARD(wbq_pkg::HAZ_FLUSH), .FWD_EN(1'b0)) u_flush (
    .clk(clk), .rst_n(rst_n), .stValid(stValid), .stReady(cStR), .stAddr(stAddr), .stData(stData),
    .rdReqValid(rdValid), .rdReqAddr(rdAddr), .rdReqReady(cRdR), .fwdValid(cFwV), .fwdData(cFwD),
    .memValid(cMV), .memWrite(cMW), .memAddr(cMA), .memWdata(cWd), .memReady(memReady),
    .empty(cE), .full(cF));

  int tests = 0, fails = 0;
  logic [AW+DW-1:0] expQ[$];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every completed write on u_dut is compared with the expected order (R3)
  always @(negedge clk) begin
    if (rst_n && aMV && aMW && memReady) begin
      if (expQ.size() == 0) begin
        tests++; fails++;
        $display("FAIL R3 unexpected write: actual %h expected none", {aMA, aWd});
      end else begin
        logic [AW+DW-1:0] e;
        e = expQ.pop_front();
        chk("R3", "drain order", {8'h0, aMA, aWd}, {8'h0, e});
      end
    end
  end

  task automatic doReset();
    rst_n = 0; stValid = 0; rdValid = 0; memReady = 0;
    repeat (3) @(posedge clk);
    expQ.delete();
    #1 rst_n = 1;
  endtask

  // driver: offer one store, push the expected item once u_dut takes it
  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    stValid = 1; stAddr = a; stData = d;
    forever begin
      @(negedge clk);
      if (aStR) break;
    end
    expQ.push_back({a, d});
    @(posedge clk); #1 stValid = 0;
  endtask

  task automatic drainAll();
    memReady = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (aE && bE && cE) break;
    end
    chk("R4", "empty after drain", {31'b0, aE}, 1);
    chk("R3", "all writes seen", expQ.size(), 0);
    @(posedge clk); #1 memReady = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    doReset();
    @(negedge clk);
    chk("R1", "empty", {31'b0, aE}, 1);
    chk("R1", "full", {31'b0, aF}, 0);
    chk("R1", "memValid", {31'b0, aMV}, 0);
    chk("R1", "stReady", {31'b0, aStR}, 1);

    // R2/R4: fill with memory stalled
    store(8'h10, 16'hA000); store(8'h11, 16'hA001);
    store(8'h12, 16'hA002); store(8'h13, 16'hA003);
    @(negedge clk);
    chk("R4", "full at depth", {31'b0, aF}, 1);
    chk("R4", "not empty", {31'b0, aE}, 0);
    chk("R2", "stReady low when full", {31'b0, aStR}, 0);
    chk("R3", "head address", {24'b0, aMA}, 32'h10);
    @(posedge clk); #1 stValid = 1; stAddr = 8'h14; stData = 16'hBAD0;
    @(negedge clk); chk("R2", "refused store 1", {31'b0, aStR}, 0);
    @(posedge clk);
    @(negedge clk); chk("R2", "refused store 2", {31'b0, aStR}, 0);
    @(posedge clk); #1 stValid = 0;
    drainAll();

    // R3: burst while memory ready
    memReady = 1;
    store(8'h01, 16'h1111); store(8'h02, 16'h2222); store(8'h03, 16'h3333);
    drainAll();

    // R5: non-matching read bypasses waiting stores
    store(8'h20, 16'hC020); store(8'h21, 16'hC021);
    @(posedge clk); #1 rdValid = 1; rdAddr = 8'h30;
    @(negedge clk);
    chk("R5", "read issued", {30'b0, aMV, aMW}, 32'h2);
    chk("R5", "read address", {24'b0, aMA}, 32'h30);
    chk("R5", "not ready while mem busy", {31'b0, aRdR}, 0);
    @(posedge clk); #1 memReady = 1;
    @(negedge clk);
    chk("R5", "ready follows memReady", {31'b0, aRdR}, 1);
    @(posedge clk); #1 rdValid = 0; memReady = 0;
    drainAll();

    // R6: forward youngest match
    store(8'h40, 16'h1111); store(8'h41, 16'h5555); store(8'h40, 16'h2222);
    @(posedge clk); #1 rdValid = 1; rdAddr = 8'h40;
    @(negedge clk);
    chk("R6", "fwdValid", {31'b0, aFwV}, 1);
    chk("R6", "fwdData youngest", {16'b0, aFwD}, 32'h2222);
    chk("R6", "read accepted", {31'b0, aRdR}, 1);
    chk("R6", "port still draining", {30'b0, aMV, aMW}, 32'h3);
    chk("R6", "drain head addr", {24'b0, aMA}, 32'h40);
    @(posedge clk); #1 rdValid = 0;
    drainAll();

    // R9: same-cycle store is ordered after the read
    store(8'h51, 16'h0051);
    @(posedge clk); #1;
    rdValid = 1; rdAddr = 8'h50; stValid = 1; stAddr = 8'h50; stData = 16'h0050; memReady = 1;
    @(negedge clk);
    chk("R9", "no forward of same-cycle store", {31'b0, aFwV}, 0);
    chk("R9", "read to memory", {30'b0, aMV, aMW}, 32'h2);
    chk("R9", "read accepted", {31'b0, aRdR}, 1);
    if (aStR) expQ.push_back({8'h50, 16'h0050});
    @(posedge clk); #1 rdValid = 0; stValid = 0; memReady = 0;
    drainAll();

    // R7: hold without forwarding
    doReset();
    store(8'h60, 16'h6060); store(8'h61, 16'h6161);
    @(posedge clk); #1 rdValid = 1; rdAddr = 8'h61;
    @(negedge clk);
    chk("R7", "held while match", {31'b0, bRdR}, 0);
    chk("R7", "no forward", {31'b0, bFwV}, 0);
    @(posedge clk); #1 memReady = 1;
    @(negedge clk);
    chk("R7", "drain first entry", {23'b0, bMW, bMA}, 32'h160);
    chk("R7", "still held", {31'b0, bRdR}, 0);
    @(negedge clk);
    chk("R7", "drain matching entry", {23'b0, bMW, bMA}, 32'h161);
    chk("R7", "still held 2", {31'b0, bRdR}, 0);
    @(negedge clk);
    chk("R7", "read issued after drain", {23'b0, bMW, bMA}, 32'h061);
    chk("R7", "read accepted", {31'b0, bRdR}, 1);
    @(posedge clk); #1 rdValid = 0; memReady = 0;
    drainAll();

    // R8: flush mode
    doReset();
    store(8'h70, 16'h7070); store(8'h71, 16'h7171);
    @(posedge clk); #1 rdValid = 1; rdAddr = 8'h99;
    @(negedge clk);
    chk("R8", "read waits", {31'b0, cRdR}, 0);
    chk("R8", "stores blocked", {31'b0, cStR}, 0);
    chk("R8", "write first", {23'b0, cMW, cMA}, 32'h170);
    @(posedge clk); #1 memReady = 1;
    @(negedge clk);
    chk("R8", "drain 1", {23'b0, cMW, cMA}, 32'h170);
    @(negedge clk);
    chk("R8", "drain 2", {23'b0, cMW, cMA}, 32'h171);
    chk("R8", "still waiting", {31'b0, cRdR}, 0);
    @(negedge clk);
    chk("R8", "read after empty", {23'b0, cMW, cMA}, 32'h099);
    chk("R8", "read accepted", {31'b0, cRdR}, 1);
    @(posedge clk); #1 rdValid = 0; memReady = 0;
    drainAll();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule